// File: doc/BRIEF.md
# Interrupt redirection table controller

This block collects a set of interrupt input pins and turns each one into an interrupt message for a processor. Each pin owns one entry in a redirection table. The entry holds the message fields: vector, destination ID, delivery mode and destination mode. It also holds the pin's trigger mode, its polarity and a mask bit. Software reaches the table and a few identification registers over a simple 32-bit memory-mapped bus. It writes a register select into an index register, then reads or writes the selected register through a data window.

A fired, unmasked entry produces a message on a valid/ready handshake. The processor never runs an acknowledge cycle. When several entries wait at once, the one with the highest programmed vector goes first, whatever its pin number.

Edge sources latch a pending request on each inactive-to-active transition. Level sources are held off by a remote-IRR bit after each accepted message. A write of the serviced vector to a direct end-of-interrupt register clears that bit. A direct pin-assertion register lets software raise a request on any entry by writing its pin number.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, `msg_valid` is low. Every entry reads low word 0x00010000 (only the mask bit, bit 16, is set) and high word 0x00000000.
- R2: Direct offset 0x00 is the 8-bit index register, read back in bits 7:0. Offset 0x10 is the data window onto the selected register. Entry n has its low word at select 0x10+2n and its high word at select 0x11+2n. Writable low bits: 7:0 vector, 10:8 delivery mode, 11 destination mode, 13 polarity, 15 trigger mode, 16 mask. The only writable high bits are 31:24, the destination ID. Every other bit reads 0, apart from the status bits of R8 and R11.
- R3: Select 0x01 is read-only. It reads bits 23:16 = entry count minus one (23), bit 15 = 1 and bits 7:0 = the version (0x20). All other bits read 0.
- R4: Select 0x00 holds a writable 4-bit ID in bits 27:24. Select 0x02 reads the same ID and cannot be written. Select 0x03 holds one writable bit in bit 0. Any other select that is not a table entry reads 0, and writes to it are ignored.
- R5: An edge entry (bit 15 = 0) sends exactly one message for each inactive-to-active transition of its pin. A pin held active sends nothing further.
- R6: A message carries the entry's vector, destination ID, delivery mode, destination mode and trigger mode. `msg_valid` and all message fields hold steady until `msg_ready` is seen high.
- R7: No message starts from an entry whose mask bit is set. An edge that arrives while the entry is masked is kept, and it is sent once the entry is unmasked.
- R8: A level entry (bit 15 = 1) sends a message while its pin is active and its remote-IRR bit (low bit 14, read-only) is 0. Acceptance sets remote IRR. A write to direct offset 0x40 clears remote IRR only in level entries whose vector equals bits 7:0 of the written data. A non-matching vector leaves the bit set.
- R9: When several unmasked entries wait at once, the highest vector is sent first. On equal vectors the lower pin number goes first.
- R10: Writing a pin number to direct offset 0x20 (bits 7:0) raises a request on that entry, as an edge would. A number at or above the entry count is ignored.
- R11: Low bit 12 (read-only) reads 1 while the entry has a request that has not yet been accepted, including one held on the message port. It reads 0 once the message is accepted.
- R12: Low bit 13 = 1 makes the pin active low. With bit 13 = 0 the pin is active high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_PINS | Interrupt input pins |
| bus_wr | input | 1 | Write strobe for the current offset |
| bus_addr | input | 8 | Direct register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| msg_valid | output | 1 | Interrupt message is present |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Destination ID |
| msg_mode | output | 3 | Delivery mode |
| msg_dest_logical | output | 1 | Destination mode, 1 = logical |
| msg_level | output | 1 | Source is level-triggered |

## Verification
The bench builds the block with its default parameters: 24 pins and version 0x20. With 24 pins the last table word sits at select 0x3F, and select 0x40 falls just past the table. Both boundaries are checked. A pin-assertion write of 24 falls exactly one past the last entry. Three simultaneous edges, one pair of them sharing a vector, exercise the vector ordering and the tie rule. A level source on an active-low pin covers polarity and the remote-IRR and end-of-interrupt sequence together.

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                bus_wr,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [7:0]          msg_dest,
  output logic [2:0]          msg_mode,
  output logic                msg_dest_logical,
  output logic                msg_level
);

  localparam int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int TBL_END = 16 + 2 * NUM_PINS;
  localparam logic [16:0] LO_WMASK = 17'h1AFFF;
  localparam logic [16:0] LO_RESET = 17'h10000;

  logic [7:0]  index_q;
  logic [3:0]  id_q;
  logic        boot_q;
  logic [16:0] lo_q   [NUM_PINS];
  logic [7:0]  dest_q [NUM_PINS];
  logic [NUM_PINS-1:0] act_q, pend_q, rirr_q;
  logic [IW-1:0] cap_idx;

  logic [NUM_PINS-1:0] act, mask_vec, trig_vec, req, elig, eoi_hit, sw_set, acc_vec;
  logic [7:0]  rel;
  logic        tbl_hit, sel_hi, eoi_wr, found;
  logic [IW-1:0] sel_ent, best_idx;
  logic [7:0]  best_vec;
  logic [16:0] lo_rd;
  logic        unused_bits;

  assign rel     = index_q - 8'h10;
  assign sel_ent = rel[IW:1];
  assign sel_hi  = index_q[0];
  assign tbl_hit = ({24'd0, index_q} >= 32'h10) && ({24'd0, index_q} < 32'(TBL_END));
  assign eoi_wr  = bus_wr && (bus_addr == 8'h40);
  assign acc_vec = (msg_valid && msg_ready) ? (NUM_PINS'(1) << cap_idx) : '0;
  assign unused_bits = ^{bus_wdata[23:17], rel[7:IW+1], rel[0]};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign act[g]      = irq_in[g] ^ lo_q[g][13];
    assign mask_vec[g] = lo_q[g][16];
    assign trig_vec[g] = lo_q[g][15];
    assign req[g]      = trig_vec[g] ? ((act[g] | pend_q[g]) & ~rirr_q[g]) : pend_q[g];
    assign elig[g]     = req[g] & ~mask_vec[g];
    assign eoi_hit[g]  = eoi_wr && trig_vec[g] && (lo_q[g][7:0] == bus_wdata[7:0]);
  end

  always_comb begin
    sw_set = '0;
    if (bus_wr && bus_addr == 8'h20 && bus_wdata[7:0] < 8'(NUM_PINS))
      sw_set[bus_wdata[IW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
      id_q    <= '0;
      boot_q  <= 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
        lo_q[i]   <= LO_RESET;
        dest_q[i] <= '0;
      end
    end else if (bus_wr) begin
      if (bus_addr == 8'h00) index_q <= bus_wdata[7:0];
      else if (bus_addr == 8'h10) begin
        if (tbl_hit) begin
          if (sel_hi) dest_q[sel_ent] <= bus_wdata[31:24];
          else        lo_q[sel_ent]   <= bus_wdata[16:0] & LO_WMASK;
        end else if (index_q == 8'h00) id_q <= bus_wdata[27:24];
        else if (index_q == 8'h03) boot_q <= bus_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      pend_q <= '0;
      rirr_q <= '0;
    end else begin
      act_q  <= act;
      pend_q <= (pend_q & ~acc_vec) | (act & ~act_q & ~trig_vec) | sw_set;
      rirr_q <= (rirr_q & ~eoi_hit) | (msg_level ? acc_vec : '0);
    end
  end

  always_comb begin
    found    = 1'b0;
    best_vec = '0;
    best_idx = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (elig[i] && (!found || lo_q[i][7:0] > best_vec)) begin
        found    = 1'b1;
        best_vec = lo_q[i][7:0];
        best_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid        <= 1'b0;
      cap_idx          <= '0;
      msg_vector       <= '0;
      msg_dest         <= '0;
      msg_mode         <= '0;
      msg_dest_logical <= 1'b0;
      msg_level        <= 1'b0;
    end else if (msg_valid) begin
      if (msg_ready) msg_valid <= 1'b0;
    end else if (found) begin
      msg_valid        <= 1'b1;
      cap_idx          <= best_idx;
      msg_vector       <= best_vec;
      msg_dest         <= dest_q[best_idx];
      msg_mode         <= lo_q[best_idx][10:8];
      msg_dest_logical <= lo_q[best_idx][11];
      msg_level        <= lo_q[best_idx][15];
    end
  end

  always_comb begin
    lo_rd     = lo_q[sel_ent];
    lo_rd[12] = req[sel_ent];
    lo_rd[14] = rirr_q[sel_ent];
    bus_rdata = '0;
    if (bus_addr == 8'h00) bus_rdata = {24'd0, index_q};
    else if (bus_addr == 8'h10) begin
      if (tbl_hit) bus_rdata = sel_hi ? {dest_q[sel_ent], 24'd0} : {15'd0, lo_rd};
      else begin
        case (index_q)
          8'h00:   bus_rdata = {4'd0, id_q, 24'd0};
          8'h01:   bus_rdata = {8'd0, 8'(NUM_PINS - 1), 8'h80, VERSION};
          8'h02:   bus_rdata = {4'd0, id_q, 24'd0};
          8'h03:   bus_rdata = {31'd0, boot_q};
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  p_msg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest) && $stable(msg_mode));

  p_unmasked_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> ($past(mask_vec) & (NUM_PINS'(1) << cap_idx)) == '0);

  p_rirr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && msg_level |=> (rirr_q & (NUM_PINS'(1) << $past(cap_idx))) != '0);

  p_rirr_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) && msg_level |-> ($past(rirr_q) & (NUM_PINS'(1) << cap_idx)) == '0);

endmodule

// File: tb/irq_route_ctrl_test.sv
module irq_route_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  logic [23:0] irq_in;
  logic bus_wr;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic msg_valid, msg_ready, msg_dest_logical, msg_level;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_mode;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [20:0] exp_q[$];

  irq_route_ctrl uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_mode(msg_mode),
    .msg_dest_logical(msg_dest_logical), .msg_level(msg_level));

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [20:0] mk(input logic [7:0] v, input logic [7:0] d, input logic [2:0] m,
                                     input logic dl, input logic lv);
    return {v, d, m, dl, lv};
  endfunction

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      logic [20:0] got, e;
      got = {msg_vector, msg_dest, msg_mode, msg_dest_logical, msg_level};
      if (exp_q.size() == 0) chk(0, "R5/R7/R8 unexpected message", {11'd0, got}, 32'd0);
      else begin
        e = exp_q.pop_front();
        chk(got == e, "R6/R9 message content/order", {11'd0, got}, {11'd0, e});
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_wr = 0; bus_addr = a; #1 d = bus_rdata;
  endtask
  task automatic wr_ind(input logic [7:0] s, input logic [31:0] d);
    wr(8'h00, {24'd0, s}); wr(8'h10, d);
  endtask
  task automatic rd_ind(input logic [7:0] s, output logic [31:0] d);
    wr(8'h00, {24'd0, s}); rd(8'h10, d);
  endtask
  task automatic prog(input int n, input logic [7:0] dest, input logic [31:0] lo);
    wr_ind(8'(8'h11 + 2*n), {dest, 24'd0});
    wr_ind(8'(8'h10 + 2*n), lo);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_ready(input logic v);
    @(posedge clk); #2 msg_ready = v;
  endtask
  task automatic drained(input string tag);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v0;
    rst_n = 0; irq_in = '0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; msg_ready = 1;
    idle(4); rst_n = 1; idle(2);

    chk(msg_valid == 0, "R1 msg_valid after reset", {31'd0, msg_valid}, 0);
    rd_ind(8'h10, d); chk(d == 32'h00010000, "R1 entry0 low", d, 32'h00010000);
    rd_ind(8'h3E, d); chk(d == 32'h00010000, "R1 entry23 low", d, 32'h00010000);
    rd_ind(8'h3F, d); chk(d == 32'h0, "R1 entry23 high", d, 0);

    rd_ind(8'h01, d); chk(d == 32'h00178020, "R3 version", d, 32'h00178020);
    wr_ind(8'h01, 32'hFFFFFFFF);
    rd_ind(8'h01, d); chk(d == 32'h00178020, "R3 version read-only", d, 32'h00178020);

    wr_ind(8'h00, 32'hFAFFFFFF);
    rd_ind(8'h00, d); chk(d == 32'h0A000000, "R4 id", d, 32'h0A000000);
    wr_ind(8'h02, 32'h05000000);
    rd_ind(8'h02, d); chk(d == 32'h0A000000, "R4 arbitration id", d, 32'h0A000000);
    wr_ind(8'h03, 32'hFFFFFFFF);
    rd_ind(8'h03, d); chk(d == 32'h1, "R4 boot bit", d, 1);
    wr_ind(8'h05, 32'hFFFFFFFF);
    rd_ind(8'h05, d); chk(d == 32'h0, "R4 unimplemented select", d, 0);
    rd_ind(8'h40, d); chk(d == 32'h0, "R4 select past table", d, 0);
    rd(8'h00, d); chk(d == 32'h40, "R2 index readback", d, 32'h40);

    wr_ind(8'h3E, 32'hFFFF5FFF);
    rd_ind(8'h3E, d); chk(d == 32'h00010FFF, "R2 low writable bits", d, 32'h00010FFF);
    wr_ind(8'h3F, 32'hFFFFFFFF);
    rd_ind(8'h3F, d); chk(d == 32'hFF000000, "R2 high writable bits", d, 32'hFF000000);
    wr_ind(8'h3E, 32'h00010000);

    // R5 edge entry
    prog(1, 8'h12, 32'h00000931);
    exp_q.push_back(mk(8'h31, 8'h12, 3'd1, 1'b1, 1'b0));
    @(negedge clk); irq_in[1] = 1; idle(10);
    drained("R5 one message per edge");
    @(negedge clk); irq_in[1] = 0; idle(4);
    exp_q.push_back(mk(8'h31, 8'h12, 3'd1, 1'b1, 1'b0));
    @(negedge clk); irq_in[1] = 1; @(negedge clk); irq_in[1] = 0; idle(6);
    drained("R5 second edge");

    // R6 hold and R11 status
    set_ready(0);
    exp_q.push_back(mk(8'h31, 8'h12, 3'd1, 1'b1, 1'b0));
    @(negedge clk); irq_in[1] = 1; @(negedge clk); irq_in[1] = 0; idle(3);
    chk(msg_valid == 1, "R6 valid held", {31'd0, msg_valid}, 1);
    v0 = {24'd0, msg_vector};
    idle(3);
    chk(msg_valid == 1 && msg_vector == v0[7:0], "R6 stable while not ready", {24'd0, msg_vector}, v0);
    rd_ind(8'h12, d); chk(d[12] == 1, "R11 status while held", d, d | 32'h1000);
    set_ready(1); idle(4);
    rd_ind(8'h12, d); chk(d[12] == 0, "R11 status after accept", d, d & ~32'h1000);
    drained("R6 held message delivered");

    // R7 masked edge kept
    prog(2, 8'h02, 32'h00010022);
    @(negedge clk); irq_in[2] = 1; @(negedge clk); irq_in[2] = 0; idle(8);
    chk(msg_valid == 0, "R7 masked sends nothing", {31'd0, msg_valid}, 0);
    exp_q.push_back(mk(8'h22, 8'h02, 3'd0, 1'b0, 1'b0));
    wr_ind(8'h14, 32'h00000022); idle(6);
    drained("R7 latched edge sent after unmask");

    // R9 priority
    prog(3, 8'h03, 32'h00000050);
    prog(4, 8'h04, 32'h00000090);
    prog(6, 8'h06, 32'h00000050);
    set_ready(0);
    exp_q.push_back(mk(8'h90, 8'h04, 3'd0, 1'b0, 1'b0));
    exp_q.push_back(mk(8'h50, 8'h03, 3'd0, 1'b0, 1'b0));
    exp_q.push_back(mk(8'h50, 8'h06, 3'd0, 1'b0, 1'b0));
    @(negedge clk); irq_in[3] = 1; irq_in[4] = 1; irq_in[6] = 1;
    @(negedge clk); irq_in[3] = 0; irq_in[4] = 0; irq_in[6] = 0;
    idle(3); set_ready(1); idle(12);
    drained("R9 vector order and tie");

    // R8 level with EOI
    prog(5, 8'h05, 32'h00008040);
    exp_q.push_back(mk(8'h40, 8'h05, 3'd0, 1'b0, 1'b1));
    @(negedge clk); irq_in[5] = 1; idle(8);
    drained("R8 single level message");
    rd_ind(8'h1A, d); chk(d == 32'h0000C040, "R8 remote IRR set", d, 32'h0000C040);
    wr(8'h40, 32'h41); idle(5);
    rd_ind(8'h1A, d); chk(d == 32'h0000C040, "R8 mismatched EOI ignored", d, 32'h0000C040);
    exp_q.push_back(mk(8'h40, 8'h05, 3'd0, 1'b0, 1'b1));
    wr(8'h40, 32'h40); idle(6);
    drained("R8 EOI re-enables active level");
    @(negedge clk); irq_in[5] = 0;
    wr(8'h40, 32'h40); idle(5);
    rd_ind(8'h1A, d); chk(d == 32'h00008040, "R8 EOI clears remote IRR", d, 32'h00008040);
    drained("R8 inactive level silent");

    // R12 active-low level
    prog(7, 8'h07, 32'h0001A077);
    @(negedge clk); irq_in[7] = 1; idle(2);
    wr_ind(8'h1E, 32'h0000A077); idle(6);
    chk(msg_valid == 0, "R12 high pin inactive when active low", {31'd0, msg_valid}, 0);
    exp_q.push_back(mk(8'h77, 8'h07, 3'd0, 1'b0, 1'b1));
    @(negedge clk); irq_in[7] = 0; idle(6);
    drained("R12 low pin fires");
    @(negedge clk); irq_in[7] = 1;
    wr(8'h40, 32'h77); idle(6);
    drained("R12 released pin quiet");

    // R10 pin assertion
    prog(9, 8'h09, 32'h00000055);
    exp_q.push_back(mk(8'h55, 8'h09, 3'd0, 1'b0, 1'b0));
    wr(8'h20, 32'd9); idle(6);
    drained("R10 pin assertion");
    wr(8'h20, 32'd24); wr(8'h20, 32'd200); idle(6);
    chk(msg_valid == 0, "R10 out-of-range pin ignored", {31'd0, msg_valid}, 0);
    drained("R10 no extra message");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule